// File: doc/BRIEF.md
# Multi-Format Serial Peripheral Controller

A register-mapped serial port that acts as bus master or slave. One shift engine produces three framing styles. The first is a select-framed format with programmable clock polarity and phase. The second is a synchronous format that marks each frame with a one-clock pulse. The third is a half-duplex command/response format, in which an 8-bit command goes out and a data word comes back. Software reaches the block through a 2-bit-addressed register bus.

A write to the data address queues a word into a 4-entry transmit FIFO. A read from the same address takes the oldest word from a 4-entry receive FIFO. As master, the block starts a frame whenever transmit data is waiting and divides the system clock to make the serial clock. As slave, it follows an external clock and select. It sends the queued word, or zeros when none is queued.

Top module: `serial_port_ctrl`

## Requirements
- R1: After reset the status register (address 2) reads 0x5 (bit0 transmit empty, bit2 receive empty), the serial clock output is low and the select output is high.
- R2: Writing address 0 pushes a word into a 4-deep transmit FIFO. A write while it holds 4 words is dropped. Status bit1 flags a full transmit FIFO. Words leave in write order.
- R3: Reading address 0 pops the oldest received word. Status bit3 flags a full receive FIFO. A read while the receive FIFO is empty returns 0 and changes nothing.
- R4: As master (control bit1 = 1, enable bit0 = 1), each serial clock half period lasts N+1 system clocks, where N is control bits [23:16].
- R5: Format 0 (control bits [3:2] = 0) sends the word MSB first with select low for the whole frame. The idle clock level is control bit4. With control bit5 = 0, data is sampled on the first edge of each clock cycle. With bit5 = 1, data changes on the first edge and is sampled on the second. A looped-back frame returns the sent word.
- R6: The frame size is control bits [10:6] plus one, from 4 to 32 bits. Values below 3 give a 4-bit frame. Received words are right-aligned and zero-extended.
- R7: Format 1 keeps the clock idle low and raises select for exactly the one serial clock cycle before the MSB. Data changes on rising edges and is sampled on falling edges.
- R8: Format 2, master: select goes low, the low 8 bits of the transmit word go out MSB first on 8 clocks, one clock follows with no transfer, and then a frame-size word is sampled on rising edges. The frame uses frame size + 9 rising edges.
- R9: As slave (control bit1 = 0), format 0 frames follow the external select and clock. The transmit word is taken when select falls. If the transmit FIFO is empty, zeros are sent. The word shifted in is pushed into the receive FIFO.
- R10: A completed frame that finds the receive FIFO full is discarded and sets sticky status bit5. Writing 1 to bit5 of address 2 clears it.
- R11: Status bit4 is set while a frame is in progress and clear when the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 0) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| ser_clk_o | output | 1 | Serial clock driven in master mode |
| ser_clk_i | input | 1 | Serial clock received in slave mode |
| sel_o | output | 1 | Select or frame pulse driven in master mode |
| sel_i | input | 1 | Select or frame pulse received in slave mode |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |

## Verification
Most internal faults in this block appear at the data register within a single frame. A wrong bit counter or shift edge shows up as a shifted or truncated loopback word. A select or pulse that is out of place changes the count of clock edges seen inside or outside the frame. A FIFO pointer error appears as words out of order, or as a status word that differs from the count of writes and reads made. The sticky flag and the dropped frame show up as soon as the fifth word is read back, and also in the status bits.

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl #(
  parameter int DW   = 32,
  parameter int FD   = 4,
  parameter int DIVW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          ser_clk_o,
  input  logic          ser_clk_i,
  output logic          sel_o,
  input  logic          sel_i,
  output logic          sd_o,
  input  logic          sd_i
);
  localparam int FAW = $clog2(FD);
  localparam int SZW = $clog2(DW);
  localparam int CW  = SZW + 2;

  logic            en, mst, cpol, cpha, ovf, active, half;
  logic [1:0]      fmt;
  logic [SZW-1:0]  szm1;
  logic [DIVW-1:0] div, divcnt;
  logic [DW-1:0]   txm [FD];
  logic [DW-1:0]   rxm [FD];
  logic [FAW:0]    tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0]   cyc;
  logic [DW-1:0]   tsh, rsh;
  logic [2:0]      sck_s, sel_s;
  logic [1:0]      sd_s;

  wire [FAW:0] tx_cnt   = tx_wp - tx_rp;
  wire [FAW:0] rx_cnt   = rx_wp - rx_rp;
  wire tx_empty = tx_cnt == '0;
  wire rx_empty = rx_cnt == '0;
  wire tx_full  = tx_cnt == (FAW+1)'(FD);
  wire rx_full  = rx_cnt == (FAW+1)'(FD);

  wire is_ti  = fmt == 2'd1;
  wire is_mw  = fmt == 2'd2;
  wire is_mot = !is_ti && !is_mw;
  wire pol    = is_mot & cpol;
  wire late   = is_ti | (is_mot & cpha);

  wire [CW-1:0] sz        = CW'((szm1 < SZW'(3)) ? SZW'(3) : szm1) + CW'(1);
  wire [CW-1:0] t_last    = is_ti ? sz : is_mw ? sz + CW'(8) : sz - CW'(1);
  wire [CW-1:0] out_first = is_ti ? CW'(1) : (is_mw && !mst) ? CW'(9) : CW'(0);
  wire [CW-1:0] in_first  = is_ti ? CW'(1) : (is_mw && mst) ? CW'(9) : CW'(0);
  wire [CW-1:0] nin       = (is_mw && !mst) ? CW'(8) : sz;

  wire wr_data = reg_wr && reg_addr == 2'd0;
  wire wr_ctrl = reg_wr && reg_addr == 2'd1;
  wire wr_stat = reg_wr && reg_addr == 2'd2;
  wire tx_push = wr_data && !tx_full;
  wire rx_pop  = reg_rd && reg_addr == 2'd0 && !rx_empty;

  wire s_sck    = sck_s[1] ^ pol;
  wire s_sck_d  = sck_s[2] ^ pol;
  wire s_lead   = s_sck && !s_sck_d;
  wire s_trail  = !s_sck && s_sck_d;
  wire m_tick   = active && divcnt == div;
  wire lead_ev  = active && (mst ? (m_tick && !half) : s_lead);
  wire trail_ev = active && (mst ? (m_tick && half) : s_trail);

  wire start  = en && !active &&
                (mst ? !tx_empty : is_ti ? (s_lead && sel_s[1]) : (sel_s[2] && !sel_s[1]));
  wire abort  = active && !mst && !is_ti && sel_s[1];
  wire end_ev = trail_ev && cyc == t_last;
  wire samp   = (late ? trail_ev : lead_ev) && cyc >= in_first && cyc < in_first + nin;
  wire shft   = late ? (lead_ev && cyc > out_first) : (trail_ev && cyc >= out_first);
  wire sdin   = mst ? sd_i : sd_s[1];

  wire [DW-1:0] rsh_n   = samp ? {rsh[DW-2:0], sdin} : rsh;
  wire [DW-1:0] rx_word = rsh_n & ({DW{1'b1}} >> (CW'(DW) - nin));
  wire          rx_push = end_ev && !rx_full;
  wire          tx_pop  = start && !tx_empty;
  wire [DW-1:0] tx_head = tx_empty ? '0 : txm[tx_rp[FAW-1:0]];
  wire [DW-1:0] load    = (is_mw && mst) ? {tx_head[7:0], {(DW-8){1'b0}}}
                                         : tx_head << (CW'(DW) - sz);

  wire unused_bits = ^{reg_wdata[DW-1:16+DIVW], reg_wdata[15:6+SZW]};

  assign ser_clk_o = pol ^ (mst && active && half);
  assign sel_o     = is_ti ? (mst && active && cyc == '0) : !(mst && active);
  assign sd_o      = active && tsh[DW-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {en, mst, cpol, cpha, fmt, szm1, div, ovf} <= '0;
      sck_s <= '0; sel_s <= '0; sd_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], ser_clk_i};
      sel_s <= {sel_s[1:0], sel_i};
      sd_s  <= {sd_s[0], sd_i};
      if (wr_ctrl) begin
        en   <= reg_wdata[0];
        mst  <= reg_wdata[1];
        fmt  <= reg_wdata[3:2];
        cpol <= reg_wdata[4];
        cpha <= reg_wdata[5];
        szm1 <= reg_wdata[6 +: SZW];
        div  <= reg_wdata[16 +: DIVW];
      end
      if (end_ev && rx_full) ovf <= 1'b1;
      else if (wr_stat && reg_wdata[5]) ovf <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0; half <= 1'b0; cyc <= '0; divcnt <= '0; tsh <= '0; rsh <= '0;
    end else if (start) begin
      active <= 1'b1; half <= 1'b0; cyc <= '0; divcnt <= '0; tsh <= load; rsh <= '0;
    end else if (!en || abort || end_ev) begin
      active <= 1'b0;
    end else if (active) begin
      if (mst) divcnt <= m_tick ? '0 : divcnt + 1'b1;
      if (lead_ev) half <= 1'b1;
      if (trail_ev) begin half <= 1'b0; cyc <= cyc + 1'b1; end
      if (shft) tsh <= tsh << 1;
      rsh <= rsh_n;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
    end

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp[FAW-1:0]] <= reg_wdata;
    if (rx_push) rxm[rx_wp[FAW-1:0]] <= rx_word;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata = rx_empty ? '0 : rxm[rx_rp[FAW-1:0]];
      2'd1: begin
        reg_rdata[3:0]        = {fmt, mst, en};
        reg_rdata[5:4]        = {cpha, cpol};
        reg_rdata[6 +: SZW]   = szm1;
        reg_rdata[16 +: DIVW] = div;
      end
      2'd2: reg_rdata[5:0] = {ovf, active, rx_full, rx_empty, tx_full, tx_empty};
      default: reg_rdata = '0;
    endcase
  end
endmodule

module serial_port_ctrl_chk #(
  parameter int FAW = 2,
  parameter int FD  = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [FAW:0] tx_cnt,
  input logic [FAW:0] rx_cnt,
  input logic         tx_push,
  input logic         tx_pop,
  input logic         rx_push,
  input logic         rx_pop,
  input logic         ovf,
  input logic         clr_w,
  input logic         mst,
  input logic         busy,
  input logic [1:0]   fmt,
  input logic         cpol,
  input logic         ser_clk_o
);
  a_r2_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= (FAW+1)'(FD));
  a_r2_tx_push_count: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push && !tx_pop |=> tx_cnt == $past(tx_cnt) + 1'b1);
  a_r3_rx_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop && !rx_push |=> rx_cnt == $past(rx_cnt) - 1'b1);
  a_r3_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= (FAW+1)'(FD));
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr_w |=> ovf);
  a_r11_idle_clock_still: assert property (@(posedge clk) disable iff (!rst_n)
    mst && !busy && $past(mst && !busy) && $stable(fmt) && $stable(cpol) |-> $stable(ser_clk_o));
endmodule

bind serial_port_ctrl serial_port_ctrl_chk #(.FAW(FAW), .FD(FD)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
  .ovf(ovf), .clr_w(wr_stat && reg_wdata[5]), .mst(mst), .busy(active),
  .fmt(fmt), .cpol(cpol), .ser_clk_o(ser_clk_o));

// File: tb/serial_port_ctrl_bench.sv
module serial_port_ctrl_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, reg_wr, reg_rd, ser_clk_i, sel_i;
  logic [1:0]  reg_addr, src;
  logic [31:0] reg_wdata, reg_rdata;
  logic        ser_clk_o, sel_o, sd_o, mw_sd, slv_sd, dut_sd_i, cnt_clr, sck_prev;
  logic [7:0]  cmd;
  logic [11:0] resp;
  int          r_hi, r_lo, mwr, mwf, checks, errors;
  bit          done;

  assign dut_sd_i = (src == 2'd0) ? sd_o : (src == 2'd1) ? mw_sd : slv_sd;

  serial_port_ctrl u_serial_port_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_clk_o(ser_clk_o),
    .ser_clk_i(ser_clk_i), .sel_o(sel_o), .sel_i(sel_i), .sd_o(sd_o), .sd_i(dut_sd_i));

  // edge counters and a command/response slave model for format 2
  always @(negedge clk) begin
    if (cnt_clr) begin r_hi <= 0; r_lo <= 0; end
    else if (ser_clk_o && !sck_prev) begin
      if (sel_o) r_hi <= r_hi + 1; else r_lo <= r_lo + 1;
    end
    if (sel_o) begin mwr <= 0; mwf <= 0; mw_sd <= 1'b0; end
    else begin
      if (ser_clk_o && !sck_prev) begin
        if (mwr < 8) cmd <= {cmd[6:0], sd_o};
        mwr <= mwr + 1;
      end
      if (!ser_clk_o && sck_prev) begin
        mwf <= mwf + 1;
        if (mwf + 1 >= 9 && mwf + 1 - 9 < 12) mw_sd <= resp[11 - (mwf + 1 - 9)];
      end
    end
    sck_prev <= ser_clk_o;
  end

  localparam logic [48:0] VEC [7] = '{
    {2'd0, 1'b0, 1'b0, 5'd7,  8'd1, 32'h0000_00A5},
    {2'd0, 1'b0, 1'b1, 5'd15, 8'd2, 32'h1234_ABCD},
    {2'd0, 1'b1, 1'b0, 5'd31, 8'd0, 32'hDEAD_BEEF},
    {2'd0, 1'b1, 1'b1, 5'd3,  8'd1, 32'h0000_007B},
    {2'd1, 1'b0, 1'b0, 5'd11, 8'd1, 32'hF0F0_F5A3},
    {2'd1, 1'b0, 1'b0, 5'd31, 8'd0, 32'h8000_0001},
    {2'd0, 1'b0, 1'b0, 5'd1,  8'd0, 32'h0000_003D}
  };

  function automatic logic [31:0] ctrl(input logic e, m, input logic [1:0] f,
                                       input logic cp, ch, input logic [4:0] s, input logic [7:0] d);
    return {8'd0, d, 5'd0, s, ch, cp, f, m, e};
  endfunction

  function automatic int fsize(input logic [4:0] s);
    return (s < 5'd3) ? 4 : int'(s) + 1;
  endfunction

  function automatic logic [31:0] msk(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : (32'h1 << n) - 32'h1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 5000; k++) begin
      rd(2'd2, s);
      if (!s[4] && s[0]) break;
    end
  endtask

  task automatic clr_cnt();
    cnt_clr = 1'b1; @(negedge clk); #1 cnt_clr = 1'b0;
  endtask

  task automatic slave_frame(input logic [7:0] din, output logic [7:0] cap);
    sel_i = 1'b0; repeat (8) @(negedge clk);
    for (int b = 7; b >= 0; b--) begin
      slv_sd = din[b]; repeat (8) @(negedge clk);
      cap = {cap[6:0], sd_o}; ser_clk_i = 1'b1; repeat (8) @(negedge clk);
      ser_clk_i = 1'b0;
    end
    repeat (8) @(negedge clk); sel_i = 1'b1; repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  cap;
    logic        p, r;
    int          n;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    ser_clk_i = 1'b0; sel_i = 1'b1; slv_sd = 1'b0; src = 2'd0; cnt_clr = 1'b0;
    resp = 12'hB6E; cmd = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd2, d);
    chk("R1 status", d, 32'h5);
    chk("R1 clock idle", {31'd0, ser_clk_o}, 32'd0);
    chk("R1 select idle", {31'd0, sel_o}, 32'd1);

    // loopback vectors over formats, modes and sizes (R5, R6, R7)
    for (int i = 0; i < 7; i++) begin
      automatic logic [1:0] f  = VEC[i][48:47];
      automatic logic       cp = VEC[i][46];
      automatic logic       ch = VEC[i][45];
      automatic logic [4:0] s  = VEC[i][44:40];
      automatic string      tag = (i == 6) ? "R6 clamp" : (f == 2'd1) ? "R7 loop" : "R5 loop";
      wr(2'd1, ctrl(1'b1, 1'b1, f, cp, ch, s, VEC[i][39:32]));
      clr_cnt();
      wr(2'd0, VEC[i][31:0]);
      wait_idle();
      rd(2'd0, d);
      chk(tag, d, VEC[i][31:0] & msk(fsize(s)));
      if (!cp) begin
        chk(tag, r_lo, fsize(s));
        chk(tag, r_hi, (f == 2'd1) ? 1 : 0);
      end
    end

    // R4: half period of N+1 clocks, N = 3
    wr(2'd1, ctrl(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 5'd7, 8'd3));
    wr(2'd0, 32'h5A);
    p = ser_clk_o;
    do begin @(negedge clk); r = ser_clk_o && !p; p = ser_clk_o; end while (!r);
    n = 0;
    do begin @(negedge clk); n++; r = ser_clk_o && !p; p = ser_clk_o; end while (!r);
    chk("R4 period", n, 8);
    wait_idle();
    rd(2'd0, d);

    // R11: busy during a frame
    wr(2'd1, ctrl(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 5'd15, 8'd7));
    wr(2'd0, 32'hBEEF);
    repeat (4) @(negedge clk);
    rd(2'd2, d);
    chk("R11 busy set", {31'd0, d[4]}, 32'd1);
    wait_idle();
    rd(2'd2, d);
    chk("R11 busy clear", d, 32'h1);
    rd(2'd0, d);

    // R8: command/response format
    src = 2'd1;
    wr(2'd1, ctrl(1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 5'd11, 8'd1));
    clr_cnt();
    wr(2'd0, 32'h0000_12A5);
    wait_idle();
    chk("R8 command", {24'd0, cmd}, 32'hA5);
    rd(2'd0, d);
    chk("R8 response", d, 32'hB6E);
    chk("R8 edges", r_lo, 21);
    src = 2'd0;

    // R2, R10, R3: FIFO depth, order, overflow
    wr(2'd1, ctrl(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 5'd7, 8'd0));
    for (int k = 1; k <= 5; k++) wr(2'd0, 32'h11 * k);
    rd(2'd2, d);
    chk("R2 tx full", d, 32'h6);
    wr(2'd1, ctrl(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 5'd7, 8'd0));
    wait_idle();
    rd(2'd2, d);
    chk("R3 rx full", d, 32'h9);
    wr(2'd0, 32'h66);
    wait_idle();
    rd(2'd2, d);
    chk("R10 overflow set", d, 32'h29);
    for (int k = 1; k <= 4; k++) begin
      rd(2'd0, d);
      chk("R2 order", d, 32'h11 * k);
    end
    rd(2'd0, d);
    chk("R3 empty read", d, 32'h0);
    rd(2'd2, d);
    chk("R10 sticky", d, 32'h25);
    wr(2'd2, 32'h20);
    rd(2'd2, d);
    chk("R10 clear", d, 32'h5);

    // R9: slave, format 0
    src = 2'd2;
    wr(2'd1, ctrl(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 5'd7, 8'd0));
    wr(2'd0, 32'h3C);
    repeat (4) @(negedge clk);
    slave_frame(8'h96, cap);
    chk("R9 slave out", {24'd0, cap}, 32'h3C);
    rd(2'd0, d);
    chk("R9 slave in", d, 32'h96);
    slave_frame(8'h5A, cap);
    chk("R9 empty sends zero", {24'd0, cap}, 32'h0);
    rd(2'd0, d);
    chk("R9 slave in 2", d, 32'h5A);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule